// File: doc/BRIEF.md
# Triple-Modulus Clock Prescaler

This block divides a fast input clock by 64, 65 or 72. Two static control bits choose the ratio. It is meant to sit in front of a slower synthesizer counter, which needs one coarse edge per division period. The block counts rising input edges with two cascaded stages. A front stage divides by 4, or by 5 when it is told to swallow an extra edge. A back counter advances once per front-stage wrap and counts either 16 or 18 steps. A small control unit picks the back counter length and decides when the front stage swallows.

The divided output is a single registered bit. It goes low on the edge that completes a period and goes high again on the 32nd edge of the next period, so it is roughly half duty. The control bits are latched only at period boundaries. A change made mid-period therefore never shortens or stretches the period in flight.

Top module: `triple_prescaler`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, both stages return to count 0 and `div_out` is 1 after that edge.
- R2: The first full period after reset ends counts from the control bits applied during reset. It has exactly the modulus those bits select.
- R3: `ctl_ext`=0 with `ctl_base`=1 gives a period of 64 input edges, measured between consecutive falling edges of `div_out`.
- R4: `ctl_ext`=0 with `ctl_base`=0 gives a period of 65 input edges.
- R5: `ctl_ext`=1 gives a period of 72 input edges for either value of `ctl_base`. In this mode the front stage never divides by 5.
- R6: `div_out` falls on the input edge that completes a period.
- R7: `div_out` rises on the 32nd input edge of every period that follows a falling edge.
- R8: The control bits are sampled only on the edge that ends a period. A change at any other time affects the period after the current one and leaves the current one unchanged.
- R9: In the 65 mode the front stage divides by 5 only during the last back-counter step of a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided; rising edges are counted |
| rst | input | 1 | Synchronous active-high reset |
| ctl_base | input | 1 | Ratio select: 1 for 64, 0 for 65 (when `ctl_ext` is 0) |
| ctl_ext | input | 1 | Ratio select: 1 forces 72 |
| div_out | output | 1 | Divided output: falls at period end, rises at edge 32 |

## Verification
The bench builds the block with its default parameters: a base front ratio of 4, back lengths of 16 and 18, and a rise point of 32. These values reach all three ratios and the one-edge swallow in the final back step. The rise point then lands exactly at the midpoint of the 64 period. The control bits change at several offsets inside periods, including a few edges before a boundary, so the one-period latency is exercised. A reset is also issued while the output is low, with the long ratio selected.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

    typedef enum logic [1:0] {
        MODE_BASE    = 2'd0,
        MODE_SWALLOW = 2'd1,
        MODE_LONG    = 2'd2
    } mode_e;

    localparam int DEF_PRE_BASE   = 4;
    localparam int DEF_BACK_SHORT = 16;
    localparam int DEF_BACK_LONG  = 18;
    localparam int DEF_RISE_EDGE  = 32;

    typedef struct packed {
        logic swallow;
        logic long_len;
        logic period_end;
        logic rise_hit;
    } ctrl_t;

    function automatic mode_e decode_mode(input logic base_sel, input logic ext_sel);
        if (ext_sel) begin
            return MODE_LONG;
        end else if (base_sel) begin
            return MODE_BASE;
        end
        return MODE_SWALLOW;
    endfunction

endpackage

// File: rtl/prescale_front.sv
module prescale_front #(
    parameter int PRE_BASE = 4,
    parameter int FW       = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          swallow,
    output logic [FW-1:0] cnt_o,
    output logic          wrap_o
);
    localparam logic [FW-1:0] LAST_BASE = FW'(PRE_BASE - 1);
    localparam logic [FW-1:0] LAST_SW   = FW'(PRE_BASE);

    logic [FW-1:0] cnt_q;

    always_comb begin
        wrap_o = (cnt_q == (swallow ? LAST_SW : LAST_BASE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wrap_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/prescale_back.sv
module prescale_back #(
    parameter int BACK_SHORT = 16,
    parameter int BACK_LONG  = 18,
    parameter int BW         = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic          long_len,
    output logic [BW-1:0] cnt_o,
    output logic          last_o
);
    localparam logic [BW-1:0] END_SHORT = BW'(BACK_SHORT - 1);
    localparam logic [BW-1:0] END_LONG  = BW'(BACK_LONG - 1);

    logic [BW-1:0] cnt_q;

    always_comb begin
        last_o = (cnt_q == (long_len ? END_LONG : END_SHORT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= last_o ? '0 : cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/prescale_ctrl.sv
module prescale_ctrl
    import prescale_pkg::*;
#(
    parameter int RISE_BACK = 7,
    parameter int BW        = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          base_sel,
    input  logic          ext_sel,
    input  logic          front_wrap,
    input  logic          back_last,
    input  logic [BW-1:0] back_cnt,
    output mode_e         mode_o,
    output ctrl_t         ctrl_o,
    output logic          div_out_o
);
    mode_e mode_q;
    logic  out_q;

    always_comb begin
        ctrl_o.long_len   = (mode_q == MODE_LONG);
        ctrl_o.swallow    = (mode_q == MODE_SWALLOW) && back_last;
        ctrl_o.period_end = front_wrap && back_last;
        ctrl_o.rise_hit   = front_wrap && (back_cnt == BW'(RISE_BACK));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= decode_mode(base_sel, ext_sel);
        end else if (ctrl_o.period_end) begin
            mode_q <= decode_mode(base_sel, ext_sel);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b1;
        end else if (ctrl_o.period_end) begin
            out_q <= 1'b0;
        end else if (ctrl_o.rise_hit) begin
            out_q <= 1'b1;
        end
    end

    assign mode_o    = mode_q;
    assign div_out_o = out_q;
endmodule

// File: rtl/triple_prescaler.sv
module triple_prescaler
    import prescale_pkg::*;
#(
    parameter int PRE_BASE   = DEF_PRE_BASE,
    parameter int BACK_SHORT = DEF_BACK_SHORT,
    parameter int BACK_LONG  = DEF_BACK_LONG,
    parameter int RISE_EDGE  = DEF_RISE_EDGE
) (
    input  logic clk,
    input  logic rst,
    input  logic ctl_base,
    input  logic ctl_ext,
    output logic div_out
);
    localparam int FW        = $clog2(PRE_BASE + 1);
    localparam int BW        = $clog2(BACK_LONG);
    localparam int RISE_BACK = RISE_EDGE / PRE_BASE - 1;

    mode_e         mode_q;
    ctrl_t         ctl;
    logic [FW-1:0] front_cnt;
    logic          front_wrap;
    logic [BW-1:0] back_cnt;
    logic          back_last;
    logic          swallow;
    logic          period_end;
    logic          rise_hit;

    assign swallow    = ctl.swallow;
    assign period_end = ctl.period_end;
    assign rise_hit   = ctl.rise_hit;

    prescale_front #(
        .PRE_BASE (PRE_BASE),
        .FW       (FW)
    ) front_i (
        .clk     (clk),
        .rst     (rst),
        .swallow (swallow),
        .cnt_o   (front_cnt),
        .wrap_o  (front_wrap)
    );

    prescale_back #(
        .BACK_SHORT (BACK_SHORT),
        .BACK_LONG  (BACK_LONG),
        .BW         (BW)
    ) back_i (
        .clk      (clk),
        .rst      (rst),
        .advance  (front_wrap),
        .long_len (ctl.long_len),
        .cnt_o    (back_cnt),
        .last_o   (back_last)
    );

    prescale_ctrl #(
        .RISE_BACK (RISE_BACK),
        .BW        (BW)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .base_sel   (ctl_base),
        .ext_sel    (ctl_ext),
        .front_wrap (front_wrap),
        .back_last  (back_last),
        .back_cnt   (back_cnt),
        .mode_o     (mode_q),
        .ctrl_o     (ctl),
        .div_out_o  (div_out)
    );
endmodule

// File: rtl/prescale_chk.sv
module prescale_chk
    import prescale_pkg::*;
#(
    parameter int FW = 3,
    parameter int BW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          div_out,
    input mode_e         mode,
    input logic [FW-1:0] front_cnt,
    input logic [BW-1:0] back_cnt,
    input logic          swallow,
    input logic          back_last,
    input logic          period_end,
    input logic          rise_hit
);
    logic rst_d;

    always @(posedge clk) begin
        rst_d <= rst;
    end

    always @(posedge clk) begin
        if (rst_d) begin
            assert_reset_state_R1: assert (div_out && front_cnt == '0 && back_cnt == '0)
                else $error("R1 reset state wrong");
        end
    end

    assert_swallow_last_R9: assert property (@(posedge clk) disable iff (rst)
        swallow |-> (mode == MODE_SWALLOW && back_last));

    assert_long_no_swallow_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LONG) |-> !swallow);

    assert_fall_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        period_end |=> !div_out);

    assert_rise_at_mid_R7: assert property (@(posedge clk) disable iff (rst)
        (rise_hit && !period_end) |=> div_out);

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(mode));
endmodule

bind triple_prescaler prescale_chk #(
    .FW (FW),
    .BW (BW)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .div_out    (div_out),
    .mode       (mode_q),
    .front_cnt  (front_cnt),
    .back_cnt   (back_cnt),
    .swallow    (swallow),
    .back_last  (back_last),
    .period_end (period_end),
    .rise_hit   (rise_hit)
);

// File: tb/triple_prescaler_tb.sv
module triple_prescaler_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_base = 1'b1;
    logic ctl_ext = 1'b0;
    logic div_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    logic  rst_q = 1'b1;
    int    cnt = 0;
    int    rise_at = -1;
    bit    first = 1'b1;
    logic  prev_out = 1'b1;
    event  fall_ev;

    triple_prescaler dut_i (
        .clk      (clk),
        .rst      (rst),
        .ctl_base (ctl_base),
        .ctl_ext  (ctl_ext),
        .div_out  (div_out)
    );

    always #2 clk = ~clk;

    always @(posedge clk) rst_q <= rst;

    function automatic int ratio(input logic b, input logic e);
        if (e) return 72;
        if (b) return 64;
        return 65;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected period lengths at every falling edge of div_out
    always @(negedge clk) begin
        if (rst_q) begin
            cnt = 0;
            rise_at = -1;
            first = 1'b1;
            check(div_out === 1'b1, "R1 output high in reset", int'(div_out), 1);
            prev_out = div_out;
        end else begin
            cnt++;
            if (prev_out && !div_out) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected period end", cnt, 0);
                end else begin
                    check(cnt == exp_q[0], {tag_q[0], " R6 period length"}, cnt, exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
                if (!first) check(rise_at == 32, "R7 rise position", rise_at, 32);
                first = 1'b0;
                cnt = 0;
                rise_at = -1;
                -> fall_ev;
            end else if (!prev_out && div_out) begin
                rise_at = cnt;
            end
            prev_out = div_out;
        end
    end

    // Driver: set controls inside a period; they govern the period after the next boundary
    task automatic next_period(input logic b, input logic e, input int delay, input string tag);
        @(fall_ev);
        repeat (delay) @(negedge clk);
        ctl_base = b;
        ctl_ext  = e;
        exp_q.push_back(ratio(b, e));
        tag_q.push_back(tag);
    endtask

    task automatic do_reset(input logic b, input logic e, input string tag);
        @(negedge clk);
        ctl_base = b;
        ctl_ext  = e;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        exp_q.delete();
        tag_q.delete();
        exp_q.push_back(ratio(b, e));
        tag_q.push_back("R2");
        exp_q.push_back(ratio(b, e));
        tag_q.push_back(tag);
        rst = 1'b0;
    endtask

    initial begin
        do_reset(1'b1, 1'b0, "R3");
        next_period(1'b1, 1'b0, 0,  "R3");
        next_period(1'b0, 1'b0, 10, "R4");
        next_period(1'b0, 1'b0, 40, "R9");
        next_period(1'b0, 1'b1, 5,  "R5");
        next_period(1'b1, 1'b1, 50, "R5");
        next_period(1'b1, 1'b0, 60, "R8");
        next_period(1'b0, 1'b0, 63, "R8");
        next_period(1'b1, 1'b0, 0,  "R3");
        // reset while output is low, long ratio selected
        do_reset(1'b0, 1'b1, "R5");
        next_period(1'b0, 1'b0, 20, "R4");
        next_period(1'b1, 1'b0, 30, "R3");
        repeat (2) @(fall_ev);
        check(exp_q.size() == 0, "R8 all periods seen", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule